// File: doc/BRIEF.md
# DMA Channel Resumable Transfer Controller

This block is the control core of a single DMA channel. Software programs a data-item count, a source address, a destination address and a control word. The control word holds an enable bit and a small mode field. Once the channel is enabled, the block asks a bus engine for one beat per item. It tracks how many items are still outstanding and raises a completion flag when none remain.

The block remembers whether the channel's configuration has been touched since the last transfer began. This decides what happens when the enable bit is set again after a stop. With no configuration write in between, an interrupted transfer carries on with only the items that are left. After a configuration write, a brand-new transfer starts from the full programmed count. If the earlier transfer had already finished and nothing was written, re-enabling does nothing.

Register selection on `cfgSel`:
- 0 selects the item count, taken from the low bits of the write data.
- 1 selects the source address.
- 2 selects the destination address.
- 3 selects the control word. Bit 0 is the enable bit and bits [MODE_W:1] are the mode field.

Top module: `dma_chan_top`

## Requirements
- R1: A fresh transfer copies the last programmed item count into `remainCount` and issues exactly that many beats before stopping.
- R2: Each cycle in which `beatReq` and `beatDone` are both high decrements `remainCount` by one. It changes at no other time, except when it is loaded by a fresh start.
- R3: Writing the control word with bit 0 cleared stops the channel at a beat boundary. A beat already requested stays requested until `beatDone`, that beat is counted, and no further beat follows.
- R4: Re-enabling an interrupted channel with no configuration write in between resumes it. It issues exactly the remaining `remainCount` beats.
- R5: A write to the count, source or destination register, or a control write whose mode field differs from the stored mode, marks the configuration as changed. The next enable then starts a fresh transfer from the full programmed count.
- R6: A control write that changes only the enable bit, with the mode field equal to the stored mode, does not count as a configuration change.
- R7: When the previous transfer completed and nothing was written, setting the enable bit again issues no beat. `remainCount` stays 0 and `xferDone` stays 1.
- R8: A fresh transfer with a programmed count of zero issues no beat and sets `xferDone` in the cycle after the enabling write.
- R9: `xferDone` rises in the cycle after the last beat is accepted and is cleared by a fresh start. `beatReq` is never high while `xferDone` is high.
- R10: After reset, `beatReq`, `xferDone`, `chanEn` and `remainCount` are all 0.
- R11: `srcAddr`, `dstAddr` and `chanMode` show the last values written to their registers, one cycle after the write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| cfgWrEn | input | 1 | Configuration write strobe |
| cfgSel | input | 2 | Register select: 0 count, 1 source, 2 destination, 3 control |
| cfgWrData | input | DATA_W | Write data |
| beatDone | input | 1 | Bus engine accepted and finished the requested beat |
| beatReq | output | 1 | Beat request toward the bus engine, held until `beatDone` |
| remainCount | output | CNT_W | Items still to be transferred |
| xferDone | output | 1 | Transfer complete flag |
| chanEn | output | 1 | Stored enable bit |
| chanMode | output | MODE_W | Stored mode field |
| srcAddr | output | ADDR_W | Programmed source address |
| dstAddr | output | ADDR_W | Programmed destination address |

## Verification
A stale configuration-changed flag shows up at the ports in the first cycle after the re-enabling write. In that cycle `remainCount` either jumps back to the full count or keeps its partial value, and `beatReq` either rises or stays low, against what the write history predicts. A wrong beat-boundary stop shows one beat too many or too few in the resumed or drained count. A wrong completion flag shows either as `beatReq` rising after completion or as `xferDone` missing one cycle after the final accepted beat. The bench sweeps every count from 0 to 6 against every stop point and compares beat totals and flags with simple arithmetic.

// File: rtl/dma_chan_pkg.sv
package dma_chan_pkg;

  typedef enum logic [1:0] {
    SEL_COUNT = 2'd0,
    SEL_SRC   = 2'd1,
    SEL_DST   = 2'd2,
    SEL_CTRL  = 2'd3
  } cfgSel_e;

  // strobes from control to datapath
  typedef struct packed {
    logic loadRemain;
    logic decRemain;
  } remainCtl_t;

endpackage

// File: rtl/dma_chan_datapath.sv
module dma_chan_datapath
  import dma_chan_pkg::*;
#(
  parameter int CNT_W  = 16,
  parameter int ADDR_W = 32,
  parameter int MODE_W = 4,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              cfgWrEn,
  input  logic [1:0]        cfgSel,
  input  logic [DATA_W-1:0] cfgWrData,
  input  remainCtl_t        ctl,
  output logic              cfgChange,
  output logic              enWrite,
  output logic              enValue,
  output logic              remainZero,
  output logic              remainOne,
  output logic              shadowZero,
  output logic [CNT_W-1:0]  remainCount,
  output logic [MODE_W-1:0] chanMode,
  output logic [ADDR_W-1:0] srcAddr,
  output logic [ADDR_W-1:0] dstAddr
);

  localparam logic [CNT_W-1:0] CNT_ONE = CNT_W'(1);

  logic [CNT_W-1:0]  shadowCount;
  logic [CNT_W-1:0]  remainReg;
  logic [MODE_W-1:0] modeReg;
  logic [ADDR_W-1:0] srcReg;
  logic [ADDR_W-1:0] dstReg;
  logic [MODE_W-1:0] modeWr;
  logic              selCount, selSrc, selDst, selCtrl;

  assign selCount = cfgWrEn && (cfgSel == SEL_COUNT);
  assign selSrc   = cfgWrEn && (cfgSel == SEL_SRC);
  assign selDst   = cfgWrEn && (cfgSel == SEL_DST);
  assign selCtrl  = cfgWrEn && (cfgSel == SEL_CTRL);
  assign modeWr   = cfgWrData[MODE_W:1];

  assign enWrite   = selCtrl;
  assign enValue   = cfgWrData[0];
  assign cfgChange = selCount || selSrc || selDst || (selCtrl && (modeWr != modeReg));

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      shadowCount <= '0;
      srcReg      <= '0;
      dstReg      <= '0;
      modeReg     <= '0;
    end else begin
      if (selCount) shadowCount <= cfgWrData[CNT_W-1:0];
      if (selSrc)   srcReg      <= cfgWrData[ADDR_W-1:0];
      if (selDst)   dstReg      <= cfgWrData[ADDR_W-1:0];
      if (selCtrl)  modeReg     <= modeWr;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      remainReg <= '0;
    end else if (ctl.loadRemain) begin
      remainReg <= shadowCount;
    end else if (ctl.decRemain) begin
      remainReg <= remainReg - CNT_ONE;
    end
  end

  assign remainZero  = (remainReg == '0);
  assign remainOne   = (remainReg == CNT_ONE);
  assign shadowZero  = (shadowCount == '0);
  assign remainCount = remainReg;
  assign chanMode    = modeReg;
  assign srcAddr     = srcReg;
  assign dstAddr     = dstReg;

endmodule

// File: rtl/dma_chan_ctrl.sv
module dma_chan_ctrl
  import dma_chan_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       cfgChange,
  input  logic       enWrite,
  input  logic       enValue,
  input  logic       remainZero,
  input  logic       remainOne,
  input  logic       shadowZero,
  input  logic       beatDone,
  output remainCtl_t ctl,
  output logic       beatReq,
  output logic       xferDone,
  output logic       chanEn
);

  logic enReg, running, doneReg, dirty;
  logic dirtyNow, enRise, enEff, beatAcc, lastBeat, startFresh, resume;

  assign dirtyNow   = dirty || cfgChange;
  assign enEff      = enWrite ? enValue : enReg;
  assign enRise     = enWrite && enValue && !enReg;
  assign beatAcc    = running && beatDone;
  assign lastBeat   = beatAcc && remainOne;
  assign startFresh = enRise && !running && dirtyNow;
  assign resume     = enRise && !running && !dirtyNow && !doneReg;

  always_comb begin
    ctl            = '0;
    ctl.loadRemain = startFresh;
    ctl.decRemain  = beatAcc;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      enReg   <= 1'b0;
      running <= 1'b0;
      doneReg <= 1'b0;
      dirty   <= 1'b0;
    end else begin
      enReg <= enEff;
      dirty <= startFresh ? 1'b0 : dirtyNow;
      if (beatAcc) begin
        running <= !lastBeat && enEff;
      end else if (startFresh) begin
        running <= !shadowZero;
      end else if (resume) begin
        running <= !remainZero;
      end
      if (startFresh) begin
        doneReg <= shadowZero;
      end else if (lastBeat || (resume && remainZero)) begin
        doneReg <= 1'b1;
      end
    end
  end

  assign beatReq  = running;
  assign xferDone = doneReg;
  assign chanEn   = enReg;

endmodule

// File: rtl/dma_chan_top.sv
module dma_chan_top
  import dma_chan_pkg::*;
#(
  parameter int CNT_W  = 16,
  parameter int ADDR_W = 32,
  parameter int MODE_W = 4,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              cfgWrEn,
  input  logic [1:0]        cfgSel,
  input  logic [DATA_W-1:0] cfgWrData,
  input  logic              beatDone,
  output logic              beatReq,
  output logic [CNT_W-1:0]  remainCount,
  output logic              xferDone,
  output logic              chanEn,
  output logic [MODE_W-1:0] chanMode,
  output logic [ADDR_W-1:0] srcAddr,
  output logic [ADDR_W-1:0] dstAddr
);

  remainCtl_t ctl;
  logic cfgChange, enWrite, enValue, remainZero, remainOne, shadowZero;

  dma_chan_datapath #(
    .CNT_W(CNT_W), .ADDR_W(ADDR_W), .MODE_W(MODE_W), .DATA_W(DATA_W)
  ) u_dp (
    .clk(clk), .rstN(rstN), .cfgWrEn(cfgWrEn), .cfgSel(cfgSel), .cfgWrData(cfgWrData),
    .ctl(ctl), .cfgChange(cfgChange), .enWrite(enWrite), .enValue(enValue),
    .remainZero(remainZero), .remainOne(remainOne), .shadowZero(shadowZero),
    .remainCount(remainCount), .chanMode(chanMode), .srcAddr(srcAddr), .dstAddr(dstAddr)
  );

  dma_chan_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .cfgChange(cfgChange), .enWrite(enWrite), .enValue(enValue),
    .remainZero(remainZero), .remainOne(remainOne), .shadowZero(shadowZero),
    .beatDone(beatDone), .ctl(ctl), .beatReq(beatReq), .xferDone(xferDone), .chanEn(chanEn)
  );

endmodule

// File: rtl/dma_chan_checker.sv
module dma_chan_checker #(
  parameter int CNT_W = 16
) (
  input logic             clk,
  input logic             rstN,
  input logic             cfgWrEn,
  input logic             beatDone,
  input logic             beatReq,
  input logic [CNT_W-1:0] remainCount,
  input logic             xferDone
);

  // R2: an accepted beat lowers the count by exactly one
  p_dec_one_r2: assert property (@(posedge clk) disable iff (!rstN)
    (beatReq && beatDone) |=> (remainCount == $past(remainCount) - CNT_W'(1)));

  // R2: count is steady without an accepted beat or a write
  p_remain_stable_r2: assert property (@(posedge clk) disable iff (!rstN)
    (!(beatReq && beatDone) && !cfgWrEn) |=> $stable(remainCount));

  // R3: a requested beat is held until the bus finishes it
  p_hold_req_r3: assert property (@(posedge clk) disable iff (!rstN)
    (beatReq && !beatDone) |=> beatReq);

  // R3: an idle channel starts only on a register write
  p_idle_stays_r3: assert property (@(posedge clk) disable iff (!rstN)
    (!beatReq && !cfgWrEn) |=> !beatReq);

  // R8: never request a beat with nothing left
  p_no_empty_beat_r8: assert property (@(posedge clk) disable iff (!rstN)
    beatReq |-> (remainCount != '0));

  // R9: completion and a pending request are exclusive
  p_done_quiet_r9: assert property (@(posedge clk) disable iff (!rstN)
    xferDone |-> !beatReq);

endmodule

bind dma_chan_top dma_chan_checker #(.CNT_W(CNT_W)) u_chk (
  .clk(clk), .rstN(rstN), .cfgWrEn(cfgWrEn), .beatDone(beatDone),
  .beatReq(beatReq), .remainCount(remainCount), .xferDone(xferDone)
);

// File: tb/test_dma_chan_top.sv
`timescale 1ns/1ps
module test_dma_chan_top;
  localparam int CNT_W = 16, ADDR_W = 32, MODE_W = 4, DATA_W = 32;

  logic clk = 1'b0, rstN = 1'b0;
  logic cfgWrEn = 1'b0, beatDone = 1'b0;
  logic [1:0] cfgSel = '0;
  logic [DATA_W-1:0] cfgWrData = '0;
  logic beatReq, xferDone, chanEn;
  logic [CNT_W-1:0] remainCount;
  logic [MODE_W-1:0] chanMode;
  logic [ADDR_W-1:0] srcAddr, dstAddr;

  int nRun = 0, nFail = 0;
  bit finished = 0;

  always #2.5 clk = ~clk;

  dma_chan_top #(.CNT_W(CNT_W), .ADDR_W(ADDR_W), .MODE_W(MODE_W), .DATA_W(DATA_W)) i_dma_chan_top (
    .clk(clk), .rstN(rstN), .cfgWrEn(cfgWrEn), .cfgSel(cfgSel), .cfgWrData(cfgWrData),
    .beatDone(beatDone), .beatReq(beatReq), .remainCount(remainCount), .xferDone(xferDone),
    .chanEn(chanEn), .chanMode(chanMode), .srcAddr(srcAddr), .dstAddr(dstAddr)
  );

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    nRun++;
    if (!ok) begin
      nFail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] sel, input logic [DATA_W-1:0] d);
    @(negedge clk);
    cfgWrEn = 1'b1; cfgSel = sel; cfgWrData = d;
    @(negedge clk);
    cfgWrEn = 1'b0;
  endtask

  task automatic ctrlWr(input int mode, input bit en);
    wr(2'd3, DATA_W'((mode << 1) | int'(en)));
  endtask

  task automatic runBeats(output int cnt);
    cnt = 0;
    while (beatReq && cnt < 100) begin
      beatDone = 1'b1;
      @(negedge clk);
      cnt++;
    end
    beatDone = 1'b0;
  endtask

  task automatic oneBeat();
    beatDone = 1'b1;
    @(negedge clk);
    beatDone = 1'b0;
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    if (!finished) begin
      nFail++; nRun++;
      $display("FAIL watchdog actual=1 expected=0");
      $display("[TB] %0d tests run, %0d failed", nRun, nFail);
      $finish;
    end
  end

  initial begin : main
    int got, rem;
    repeat (3) @(negedge clk);
    // R10 reset values
    chk(!beatReq && !xferDone && !chanEn && remainCount == 0, "R10 reset", {beatReq, xferDone, chanEn}, 0);
    rstN = 1'b1;
    @(negedge clk);

    // R11 register readback
    wr(2'd1, 32'hA5A5_1234);
    wr(2'd2, 32'h0F0F_8000);
    ctrlWr(6, 1'b0);
    chk(srcAddr == 32'hA5A5_1234, "R11 src", srcAddr, 32'hA5A5_1234);
    chk(dstAddr == 32'h0F0F_8000, "R11 dst", dstAddr, 32'h0F0F_8000);
    chk(chanMode == 6, "R11 mode", chanMode, 6);
    ctrlWr(0, 1'b0);

    for (int n = 0; n <= 6; n++) begin
      for (int k = 0; k <= n; k++) begin
        ctrlWr(0, 1'b0);
        wr(2'd0, DATA_W'(n));
        ctrlWr(0, 1'b1);
        if (n == 0) begin
          chk(xferDone && !beatReq, "R8 zero count done", {xferDone, beatReq}, 2);
          continue;
        end
        chk(beatReq && remainCount == n && !xferDone, "R1 fresh load", remainCount, n);
        for (int b = 0; b < k && b < n; b++) oneBeat();
        if (k == n) begin
          chk(xferDone && !beatReq && remainCount == 0, "R9 done after last beat", remainCount, 0);
          // R7: re-enable with no write does nothing
          ctrlWr(0, 1'b0);
          ctrlWr(0, 1'b1);
          chk(!beatReq && remainCount == 0 && xferDone, "R7 idle re-enable", {beatReq, xferDone}, 1);
        end else begin
          // stall: count holds with no beatDone
          @(negedge clk);
          chk(remainCount == n - k, "R2 stall holds", remainCount, n - k);
          ctrlWr(0, 1'b0);
          chk(beatReq, "R3 in-flight beat held", beatReq, 1);
          oneBeat();
          rem = n - k - 1;
          chk(!beatReq && remainCount == rem, "R3 stop at boundary", remainCount, rem);
          chk(xferDone == (rem == 0), "R9 done on drain", xferDone, rem == 0);
          // R4/R6: enable-only write resumes
          ctrlWr(0, 1'b1);
          runBeats(got);
          if (rem == 0)
            chk(got == 0, "R7 finished drain no beats", got, 0);
          else
            chk(got == rem, "R4 resume beat count", got, rem);
          chk(xferDone && remainCount == 0, "R9 done after resume", remainCount, 0);
        end
        // R5: a config write forces a fresh full transfer
        ctrlWr(0, 1'b0);
        if (k % 3 == 0)      wr(2'd1, DATA_W'(32'h100 + k));
        else if (k % 3 == 1) wr(2'd2, DATA_W'(32'h200 + k));
        else                 ctrlWr(3, 1'b0);
        ctrlWr((k % 3 == 2) ? 3 : 0, 1'b1);
        chk(!xferDone && remainCount == n, "R5 fresh reload", remainCount, n);
        runBeats(got);
        chk(got == n, "R1 full beat count", got, n);
        chk(xferDone, "R9 done fresh", xferDone, 1);
        ctrlWr(0, 1'b0);
      end
    end

    // R6 with non-zero mode: interrupted run, mode unchanged -> resume
    ctrlWr(5, 1'b0);
    wr(2'd0, DATA_W'(4));
    ctrlWr(5, 1'b1);
    oneBeat();
    ctrlWr(5, 1'b0);
    oneBeat();
    ctrlWr(5, 1'b1);
    chk(beatReq && remainCount == 2, "R6 enable-only keeps partial", remainCount, 2);
    runBeats(got);
    chk(got == 2, "R6 resume count", got, 2);

    // R5 mode change on control while interrupted -> restart full
    wr(2'd0, DATA_W'(3));
    ctrlWr(5, 1'b0);
    ctrlWr(5, 1'b1);
    oneBeat();
    ctrlWr(5, 1'b0);
    oneBeat();
    ctrlWr(2, 1'b1);
    chk(beatReq && remainCount == 3, "R5 mode change restarts", remainCount, 3);
    runBeats(got);
    chk(got == 3, "R5 restart count", got, 3);

    finished = 1;
    $display("[TB] %0d tests run, %0d failed", nRun, nFail);
    $finish;
  end
endmodule